// File: doc/BRIEF.md
# Table-Driven Feedback Shift-Register Divider

This block is a counter-divider made of a chain of single-bit stages. On every enabled clock the chain moves one place toward its last stage, and the first stage takes in a new bit. That incoming bit is not formed by adders or exclusive-OR taps. It is read from a small table indexed by the full present register value. The same table entry also holds a carry bit, which marks the terminal state or states of the sequence. By choosing the table contents, any closed sequence of states can be built, so any count modulus below 2^N is possible.

After reset the table holds a twisted-ring pattern: the incoming bit is the inverse of the last stage. Starting from zero, this fills the register with ones and then drains it, which gives a 2N-state loop. Software or a host computes other tables elsewhere. It writes them entry by entry through a small write port while counting is paused. The register value is read as a binary number with the last stage as the msb and the first stage as the lsb.

Top module: `lutsr_divider`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the state to 0 and restores every table entry to its default contents. Reset takes priority over a table write in the same cycle.
- R2: In the default table, the data-in bit of each entry is the inverse of that state's msb. With this table and N = 4, counting from 0 visits 0, 1, 3, 7, 15, 14, 12, 8 and then repeats.
- R3: When `cnt_en` is high at a clock edge, the next state is (2*S + d) mod 2^N. Here S is the present state and d is bit 0 (data-in) of the table entry at address S.
- R4: When `cnt_en` is low, the state holds. If no table write is accepted either, `carry` also holds.
- R5: A write with `wr_en` high while `cnt_en` is low stores `wr_data` into the entry at `wr_addr`. Bit 0 is the data-in bit and bit 1 is the carry bit. The new entry drives `carry` and the feedback from the next cycle on.
- R6: A write request made while `cnt_en` is high is ignored and leaves the table unchanged.
- R7: `carry` equals bit 1 of the table entry addressed by the present state. It changes in the same cycle as the state. In the default table, only the entry for state `TERM_STATE` (default 0) has its carry bit set.
- R8: With N = 4, one particular table gives a single loop through all 16 states: 0, 1, 2, 5, 11, 6, 13, 10, 4, 9, 3, 7, 15, 14, 12, 8, repeating. In that table, data-in is 1 for states 0 and 2 through 7, data-in is 1 for state 9, and every other data-in is 0. That sequence repeats for as long as counting is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; low pauses shifting and opens the write port |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | STAGES | Table entry to write |
| wr_data | input | 2 | Entry contents: bit 1 carry, bit 0 data-in |
| state_q | output | STAGES | Present register value, last stage as msb |
| carry | output | 1 | Carry bit of the present state's entry |

## Verification
The state is registered, so a shift or reset shows on `state_q` one clock after the edge that samples `cnt_en` or `rst`. `carry` is read combinationally from the table. It therefore changes in the same cycle as the state, or one cycle after an accepted write to the entry for the present state. The bench drives every input five nanoseconds after a rising edge and samples the outputs at that same point after the next edge, so each check sees exactly one edge's worth of change. The bench judges ignored writes at the ports: it takes the next shift and checks that it still follows the old table entry.

// File: rtl/lutsr_pkg.sv
package lutsr_pkg;
  // One table entry: carry bit above, feedback bit below.
  typedef struct packed {
    logic carry;
    logic din;
  } tbl_entry_t;

  localparam int ENTRY_W = $bits(tbl_entry_t);
endpackage

// File: rtl/lutsr_table.sv
module lutsr_table
  import lutsr_pkg::*;
#(
  parameter int STAGES     = 4,
  parameter int TERM_STATE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [STAGES-1:0] waddr,
  input  tbl_entry_t        wdata,
  input  logic [STAGES-1:0] raddr,
  output tbl_entry_t        rdata
);
  localparam int DEPTH = 1 << STAGES;

  // Twisted-ring default: feed back the inverse of the top stage.
  function automatic tbl_entry_t twisted_entry(input int idx);
    tbl_entry_t e;
    logic [31:0] v;
    v       = idx;
    e.din   = ~v[STAGES-1];
    e.carry = (idx == TERM_STATE);
    return e;
  endfunction

  tbl_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= twisted_entry(i);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lutsr_stage_reg.sv
module lutsr_stage_reg #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              din,
  output logic [STAGES-1:0] state_q
);
  // Input to each stage: stage 0 takes the feedback bit, the rest take their neighbour.
  logic [STAGES-1:0] stage_in;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign stage_in[k] = din;
      end else begin : g_chain
        assign stage_in[k] = state_q[k-1];
      end

      always_ff @(posedge clk) begin
        if (rst)      state_q[k] <= 1'b0;
        else if (adv) state_q[k] <= stage_in[k];
      end
    end
  endgenerate
endmodule

// File: rtl/lutsr_divider.sv
module lutsr_divider
  import lutsr_pkg::*;
#(
  parameter int STAGES     = 4,
  parameter int TERM_STATE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [STAGES-1:0] wr_addr,
  input  logic [1:0]        wr_data,
  output logic [STAGES-1:0] state_q,
  output logic              carry
);
  tbl_entry_t fb_entry;
  tbl_entry_t tbl_wdata;
  logic       fb_din;
  logic       tbl_we;

  // Table may only change while the count is paused.
  assign tbl_we    = wr_en & ~cnt_en;
  assign tbl_wdata = tbl_entry_t'(wr_data);

  lutsr_table #(
    .STAGES    (STAGES),
    .TERM_STATE(TERM_STATE)
  ) u_table (
    .clk  (clk),
    .rst  (rst),
    .we   (tbl_we),
    .waddr(wr_addr),
    .wdata(tbl_wdata),
    .raddr(state_q),
    .rdata(fb_entry)
  );

  assign fb_din = fb_entry.din;
  assign carry  = fb_entry.carry;

  lutsr_stage_reg #(
    .STAGES(STAGES)
  ) u_stages (
    .clk    (clk),
    .rst    (rst),
    .adv    (cnt_en),
    .din    (fb_din),
    .state_q(state_q)
  );
endmodule

// File: rtl/lutsr_divider_chk.sv
module lutsr_divider_chk #(
  parameter int STAGES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              wr_en,
  input logic [STAGES-1:0] wr_addr,
  input logic [1:0]        wr_data,
  input logic [STAGES-1:0] state_q,
  input logic              carry,
  input logic              fb_din
);
  // R1: reset clears the register
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (state_q == '0));

  // R3: enabled shift takes the table bit into stage 0
  p_shift_rule_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (state_q == {$past(state_q[STAGES-2:0]), $past(fb_din)}));

  // R4: paused register holds, carry too when nothing is written
  p_hold_state_r4: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !wr_en) |=> ($stable(state_q) && $stable(carry)));

  // R5: a paused write to the present state's entry shows on carry next cycle
  p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && wr_en && (wr_addr == state_q)) |=> (carry == $past(wr_data[1])));
endmodule

bind lutsr_divider lutsr_divider_chk #(.STAGES(STAGES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cnt_en (cnt_en),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .state_q(state_q),
  .carry  (carry),
  .fb_din (fb_din)
);

// File: tb/test_lutsr_divider.sv
`timescale 1ns/1ps
module test_lutsr_divider;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [N-1:0] wr_addr = '0;
  logic [1:0]   wr_data = '0;
  logic [N-1:0] state_q;
  logic         carry;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  lutsr_divider #(.STAGES(N), .TERM_STATE(0)) i_lutsr_divider (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .state_q(state_q), .carry(carry)
  );

  // Bench's own table model: bit 1 carry, bit 0 data-in.
  logic [1:0] mdl [16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic do_reset();
    rst = 1'b1; cnt_en = 1'b0; wr_en = 1'b0;
    tick();
    rst = 1'b0;
    for (int i = 0; i < 16; i++) mdl[i] = {1'(i == 0), 1'(i < 8)};
  endtask

  task automatic t_reset();
    do_reset();
    chk(state_q == 0, "R1 state after reset", state_q, 0);
    chk(carry == 1'b1, "R1 carry at state 0", carry, 1);
    // Clear carry of entry 0, then reset must restore it (with a colliding write).
    wr_en = 1'b1; wr_addr = 0; wr_data = 2'b01;
    tick();
    chk(carry == 1'b0, "R5 carry cleared by paused write", carry, 0);
    rst = 1'b1; wr_data = 2'b00;
    tick();
    rst = 1'b0; wr_en = 1'b0;
    chk(carry == 1'b1, "R1 table default restored", carry, 1);
    chk(state_q == 0, "R1 state zero", state_q, 0);
  endtask

  task automatic t_default_loop();
    int seq [8] = '{0, 1, 3, 7, 15, 14, 12, 8};
    do_reset();
    cnt_en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      tick();
      chk(state_q == seq[(k + 1) % 8], "R2 twisted ring step", state_q, seq[(k + 1) % 8]);
      chk(carry == (state_q == 0), "R7 default carry", carry, int'(state_q == 0));
    end
    cnt_en = 1'b0;
  endtask

  task automatic t_hold();
    logic [N-1:0] s0;
    do_reset();
    cnt_en = 1'b1;
    tick(); tick(); tick();           // state 7
    cnt_en = 1'b0;
    s0 = state_q;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(state_q == s0, "R4 state holds", state_q, s0);
      chk(carry == 1'b0, "R4 carry holds", carry, 0);
    end
    cnt_en = 1'b1;
    tick();
    chk(state_q == 15, "R3 resumes after hold", state_q, 15);
    cnt_en = 1'b0;
  endtask

  task automatic t_write_ignored();
    do_reset();
    cnt_en = 1'b1; wr_en = 1'b1; wr_addr = 1; wr_data = 2'b00;
    tick();                           // 0 -> 1, write refused
    wr_en = 1'b0;
    chk(state_q == 1, "R3 first shift", state_q, 1);
    tick();                           // old entry 1 has din 1 -> 3
    chk(state_q == 3, "R6 write during count ignored", state_q, 3);
    cnt_en = 1'b0;
  endtask

  task automatic t_write_held();
    do_reset();
    wr_en = 1'b1; wr_addr = 0; wr_data = 2'b10; // carry 1, din 0
    tick();
    wr_en = 1'b0;
    chk(state_q == 0, "R4 state held during write", state_q, 0);
    cnt_en = 1'b1;
    tick();
    chk(state_q == 0, "R5 new din used (0 stays 0)", state_q, 0);
    chk(carry == 1'b1, "R7 carry from entry", carry, 1);
    cnt_en = 1'b0;
  endtask

  task automatic t_merged();
    int seq [16] = '{0, 1, 2, 5, 11, 6, 13, 10, 4, 9, 3, 7, 15, 14, 12, 8};
    logic [N-1:0] prev;
    logic [15:0] dvec = 16'b0000_0010_1111_1101; // bit i = data-in of state i
    do_reset();
    for (int i = 0; i < 16; i++) begin
      wr_en = 1'b1; wr_addr = N'(i); wr_data = {1'(i == 8), dvec[i]};
      mdl[i] = wr_data;
      tick();
    end
    wr_en = 1'b0;
    chk(state_q == 0, "R4 state held while loading", state_q, 0);
    cnt_en = 1'b1;
    for (int k = 0; k < 32; k++) begin
      prev = state_q;
      tick();
      chk(state_q == seq[(k + 1) % 16], "R8 merged sequence", state_q, seq[(k + 1) % 16]);
      chk(int'(state_q) == ((2 * int'(prev) + int'(mdl[prev][0])) % 16),
          "R3 next-state rule", state_q, (2 * int'(prev) + int'(mdl[prev][0])) % 16);
      chk(carry == mdl[state_q][1], "R7 carry at terminal", carry, mdl[state_q][1]);
    end
    cnt_en = 1'b0;
  endtask

  initial begin
    #5;
    t_reset();
    t_default_loop();
    t_hold();
    t_write_ignored();
    t_write_held();
    t_merged();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule